// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits in front of the operation engine of a parallel NOR flash model. It watches host write cycles, each carrying an address and a byte, and recognises the multi-cycle unlock sequences that start the device's operations. When a sequence completes, it raises a one-cycle start pulse for the operation the sequence names. The pulses are reset, program, chip erase, sector erase, erase suspend, erase resume and identifier mode entry. A separate pulse starts a protect-status query. The block also latches the program address and data (or the sector address) for the engine, and it keeps an operating mode: read, identifier, busy or suspended.

Which commands are legal depends on the mode. A running program or chip erase ignores writes. A running sector erase accepts only suspend. A suspended erase accepts resume and a program sequence, and nothing else. The engine reports its activity on a busy level, and the decoder leaves the busy mode when that level falls after having been seen high. In identifier mode the decoder itself answers host reads with the identifier bytes and the protect status of the addressed group.

Top module: `nor_cmd_decoder`

## Requirements
- R1: The unlock pair is AAh written to address 555h followed by 55h written to 2AAh. Only address bits 10..0 are compared in these cycles and in the command cycle that follows, so the higher address bits have no effect.
- R2: After the unlock pair, A0h to 555h arms a program. The next write of any address and data raises go_program for one cycle in the following cycle, sets op_addr and op_data to that write's address and byte, and sets mode to busy (mode 2).
- R3: The sequence unlock pair, 80h to 555h, unlock pair again, then 10h to 555h raises go_chip_erase. If the last write is instead 30h to any address, it raises go_sector_erase and sets op_addr to that address. Both set mode 2. Any other data in the sixth cycle aborts the sequence.
- R4: After the unlock pair, 90h to 555h raises go_id_enter and sets mode 1. In mode 1, a read one cycle later gives id_valid=1 and an id_data value that depends on the address. Address bits [1:0]=00 give C2h. Bit 1 clear with bit 0 set gives ADh. Bit 1 set gives {7'b0, grp_locked}, raises go_prot_query and captures rd_addr in qry_addr. Reads in any other mode leave id_valid at 0.
- R5: Out of reset, mode is 0 (read) and all pulses are low. F0h written to any address while idle in read mode or identifier mode raises go_reset and sets mode 0. F0h written while busy raises go_reset and sets mode 0 only when eng_fail is high.
- R6: A wrong address or data value at any step of a sequence returns the sequence to its start without a pulse. The mode becomes read, or stays suspended when the sequence began in suspended mode. Any write in identifier mode leaves identifier mode.
- R7: In busy mode during a program or a chip erase, every write is ignored except the failure reset of R5. Busy mode ends in the cycle after eng_busy is seen low, once it has been seen high.
- R8: In busy mode during a sector erase, B0h written to any address raises go_suspend and sets mode 3 (suspended).
- R9: In mode 3, 30h to any address raises go_resume and returns to mode 2. A program sequence is accepted there, and mode returns to 3 when that program ends. Erase and identifier sequences and F0h are refused in mode 3. Outside mode 3, 30h and B0h written alone have no effect.
- R10: A read strobe has no effect on the position within a command sequence.
- R11: At most one start pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Read address |
| eng_busy | input | 1 | Operation engine is running |
| eng_fail | input | 1 | Operation engine reports a failed operation |
| grp_locked | input | 1 | Protect status of the group at rd_addr |
| go_reset | output | 1 | Reset pulse |
| go_program | output | 1 | Program start pulse |
| go_chip_erase | output | 1 | Chip erase start pulse |
| go_sector_erase | output | 1 | Sector erase start pulse |
| go_suspend | output | 1 | Erase suspend pulse |
| go_resume | output | 1 | Erase resume pulse |
| go_id_enter | output | 1 | Identifier mode entry pulse |
| go_prot_query | output | 1 | Protect status query pulse |
| op_addr | output | AW | Latched program or sector address |
| op_data | output | 8 | Latched program data |
| qry_addr | output | AW | Address of the last protect query |
| id_valid | output | 1 | id_data holds an identifier-mode read result |
| id_data | output | 8 | Identifier or protect status byte |
| mode | output | 2 | 0 read, 1 identifier, 2 busy, 3 suspended |

## Verification
The decoder is driven with complete program, chip erase, sector erase and identifier sequences. It is also driven with sequences that break at the address of the second cycle or at the data of the third and sixth cycles. A further group is the same sequences with the upper address bits set, which shows that only the low eleven bits are compared. Command bytes are sent in every mode: reset and suspend while busy with each kind of operation, and resume, reset and erase set-up while suspended. These show that each mode admits exactly its own commands. A program inside a suspended erase shows the return to suspended mode, and a read strobe inserted in the middle of a sequence shows that the sequence position is kept.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int DW    = 8;
  localparam int KEY_W = 11;

  localparam logic [KEY_W-1:0] KEY_A1 = 11'h555;
  localparam logic [KEY_W-1:0] KEY_A2 = 11'h2AA;

  localparam logic [DW-1:0] C_UNL1 = 8'hAA;
  localparam logic [DW-1:0] C_UNL2 = 8'h55;
  localparam logic [DW-1:0] C_PGM  = 8'hA0;
  localparam logic [DW-1:0] C_ERS  = 8'h80;
  localparam logic [DW-1:0] C_ID   = 8'h90;
  localparam logic [DW-1:0] C_CHIP = 8'h10;
  localparam logic [DW-1:0] C_SECT = 8'h30;
  localparam logic [DW-1:0] C_RES  = 8'h30;
  localparam logic [DW-1:0] C_SUSP = 8'hB0;
  localparam logic [DW-1:0] C_RST  = 8'hF0;
  localparam logic [DW-1:0] ID_MFR = 8'hC2;
  localparam logic [DW-1:0] ID_DEV = 8'hAD;

  typedef enum logic [1:0] {MD_READ = 2'd0, MD_ID = 2'd1, MD_BUSY = 2'd2, MD_SUSP = 2'd3} mode_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_AA, SQ_55, SQ_PGM, SQ_E1, SQ_E2, SQ_E3} seq_e;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_CHIP, OP_SECT} op_e;

  typedef struct packed {
    logic rst;
    logic pgm;
    logic chip;
    logic sect;
    logic susp;
    logic res;
    logic id;
  } kick_t;

  // Identifier-mode response for the two low address bits.
  function automatic logic [DW-1:0] id_byte(input logic [1:0] off, input logic locked);
    if (off[1]) return {{(DW-1){1'b0}}, locked};
    return off[0] ? ID_DEV : ID_MFR;
  endfunction
endpackage

// File: rtl/nor_key_match.sv
module nor_key_match
  import nor_cmd_pkg::*;
(
  input  logic [KEY_W-1:0] key_addr,
  input  logic [DW-1:0]    key_data,
  output logic             at_a1,
  output logic             first_ok,
  output logic             second_ok
);
  logic at_a2;

  assign at_a1     = (key_addr == KEY_A1);
  assign at_a2     = (key_addr == KEY_A2);
  assign first_ok  = at_a1 && (key_data == C_UNL1);
  assign second_ok = at_a2 && (key_data == C_UNL2);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_busy,
  input  logic          eng_fail,
  input  logic          at_a1,
  input  logic          first_ok,
  input  logic          second_ok,
  output kick_t         kick,
  output mode_e         mode,
  output seq_e          seq_pos,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  seq_e          seq_q, seq_d;
  mode_e         mode_q, mode_d;
  op_e           op_q, op_d;
  logic          ret_q, ret_d;
  logic          seen_q, seen_d;
  kick_t         kick_q, kick_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          susp;
  logic          busy_done;

  assign susp      = (mode_q == MD_SUSP);
  assign busy_done = seen_q && !eng_busy;

  always_comb begin
    seq_d  = seq_q;
    mode_d = mode_q;
    op_d   = op_q;
    ret_d  = ret_q;
    seen_d = seen_q;
    kick_d = '0;
    addr_d = addr_q;
    data_d = data_q;
    if (mode_q == MD_BUSY) begin
      seen_d = seen_q | eng_busy;
      if (busy_done) begin
        mode_d = (op_q == OP_PROG && ret_q) ? MD_SUSP : MD_READ;
        op_d   = OP_NONE;
        ret_d  = 1'b0;
        seen_d = 1'b0;
      end else if (wr_en) begin
        if (eng_fail && wr_data == C_RST) begin
          kick_d.rst = 1'b1;
          mode_d     = MD_READ;
          op_d       = OP_NONE;
          ret_d      = 1'b0;
          seen_d     = 1'b0;
        end else if (op_q == OP_SECT && wr_data == C_SUSP) begin
          kick_d.susp = 1'b1;
          mode_d      = MD_SUSP;
          op_d        = OP_NONE;
          seen_d      = 1'b0;
        end
      end
    end else if (wr_en) begin
      seq_d = SQ_IDLE;
      if (mode_q == MD_ID) mode_d = MD_READ;
      unique case (seq_q)
        SQ_IDLE: begin
          if (first_ok) seq_d = SQ_AA;
          else if (!susp && wr_data == C_RST) kick_d.rst = 1'b1;
          else if (susp && wr_data == C_RES) begin
            kick_d.res = 1'b1;
            mode_d     = MD_BUSY;
            op_d       = OP_SECT;
          end
        end
        SQ_AA: if (second_ok) seq_d = SQ_55;
        SQ_55: begin
          if (at_a1 && wr_data == C_PGM) seq_d = SQ_PGM;
          else if (!susp && at_a1 && wr_data == C_ERS) seq_d = SQ_E1;
          else if (!susp && at_a1 && wr_data == C_ID) begin
            kick_d.id = 1'b1;
            mode_d    = MD_ID;
          end
        end
        SQ_PGM: begin
          kick_d.pgm = 1'b1;
          addr_d     = wr_addr;
          data_d     = wr_data;
          mode_d     = MD_BUSY;
          op_d       = OP_PROG;
          ret_d      = susp;
        end
        SQ_E1: if (first_ok) seq_d = SQ_E2;
        SQ_E2: if (second_ok) seq_d = SQ_E3;
        SQ_E3: begin
          if (at_a1 && wr_data == C_CHIP) begin
            kick_d.chip = 1'b1;
            mode_d      = MD_BUSY;
            op_d        = OP_CHIP;
          end else if (wr_data == C_SECT) begin
            kick_d.sect = 1'b1;
            addr_d      = wr_addr;
            mode_d      = MD_BUSY;
            op_d        = OP_SECT;
          end
        end
        default: seq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      mode_q <= MD_READ;
      op_q   <= OP_NONE;
      ret_q  <= 1'b0;
      seen_q <= 1'b0;
      kick_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      seq_q  <= seq_d;
      mode_q <= mode_d;
      op_q   <= op_d;
      ret_q  <= ret_d;
      seen_q <= seen_d;
      kick_q <= kick_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign kick    = kick_q;
  assign mode    = mode_q;
  assign seq_pos = seq_q;
  assign op_addr = addr_q;
  assign op_data = data_q;
endmodule

// File: rtl/nor_id_port.sv
module nor_id_port
  import nor_cmd_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          in_id,
  input  logic          grp_locked,
  output logic          id_valid,
  output logic [DW-1:0] id_data,
  output logic          prot_qry,
  output logic [AW-1:0] qry_addr
);
  logic id_hit;
  logic qry_hit;

  assign id_hit  = rd_en && in_id;
  assign qry_hit = id_hit && rd_addr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_data  <= '0;
      prot_qry <= 1'b0;
      qry_addr <= '0;
    end else begin
      id_valid <= id_hit;
      prot_qry <= qry_hit;
      if (id_hit)  id_data  <= id_byte(rd_addr[1:0], grp_locked);
      if (qry_hit) qry_addr <= rd_addr;
    end
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          eng_busy,
  input  logic          eng_fail,
  input  logic          grp_locked,
  output logic          go_reset,
  output logic          go_program,
  output logic          go_chip_erase,
  output logic          go_sector_erase,
  output logic          go_suspend,
  output logic          go_resume,
  output logic          go_id_enter,
  output logic          go_prot_query,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic [AW-1:0] qry_addr,
  output logic          id_valid,
  output logic [7:0]    id_data,
  output logic [1:0]    mode
);
  logic  at_a1;
  logic  first_ok;
  logic  second_ok;
  kick_t kick;
  mode_e mode_q;
  seq_e  seq_pos;
  logic  in_id;

  nor_key_match u_key (
    .key_addr  (wr_addr[KEY_W-1:0]),
    .key_data  (wr_data),
    .at_a1     (at_a1),
    .first_ok  (first_ok),
    .second_ok (second_ok)
  );

  nor_cmd_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .eng_busy  (eng_busy),
    .eng_fail  (eng_fail),
    .at_a1     (at_a1),
    .first_ok  (first_ok),
    .second_ok (second_ok),
    .kick      (kick),
    .mode      (mode_q),
    .seq_pos   (seq_pos),
    .op_addr   (op_addr),
    .op_data   (op_data)
  );

  assign in_id = (mode_q == MD_ID);

  nor_id_port #(.AW(AW)) u_id (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .in_id      (in_id),
    .grp_locked (grp_locked),
    .id_valid   (id_valid),
    .id_data    (id_data),
    .prot_qry   (go_prot_query),
    .qry_addr   (qry_addr)
  );

  assign go_reset        = kick.rst;
  assign go_program      = kick.pgm;
  assign go_chip_erase   = kick.chip;
  assign go_sector_erase = kick.sect;
  assign go_suspend      = kick.susp;
  assign go_resume       = kick.res;
  assign go_id_enter     = kick.id;
  assign mode            = mode_q;
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk
  import nor_cmd_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  wr_en,
  input logic  rd_en,
  input mode_e mode_q,
  input seq_e  seq_pos,
  input kick_t kick,
  input logic  id_valid
);
  assert_pgm_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kick.pgm |-> mode_q == MD_BUSY);

  assert_id_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick.id |-> mode_q == MD_ID);

  assert_id_read_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(mode_q) == MD_ID);

  assert_reset_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick.rst |-> mode_q == MD_READ);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q) == MD_BUSY |-> !(kick.pgm || kick.chip || kick.sect || kick.id || kick.res));

  assert_suspend_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kick.susp |-> (mode_q == MD_SUSP && $past(mode_q) == MD_BUSY));

  assert_susp_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q) == MD_SUSP |-> !(kick.chip || kick.sect || kick.id || kick.rst || kick.susp));

  assert_read_keeps_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> $stable(seq_pos));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kick));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .mode_q   (mode_q),
  .seq_pos  (seq_pos),
  .kick     (kick),
  .id_valid (id_valid)
);

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 21;

  localparam logic [6:0] PN = 7'h00;
  localparam logic [6:0] RT = 7'h40;
  localparam logic [6:0] PG = 7'h20;
  localparam logic [6:0] CH = 7'h10;
  localparam logic [6:0] SE = 7'h08;
  localparam logic [6:0] SU = 7'h04;
  localparam logic [6:0] RS = 7'h02;
  localparam logic [6:0] ID = 7'h01;

  typedef struct packed {
    logic [3:0]  r;
    logic        we;
    logic        busy;
    logic [23:0] a;
    logic [7:0]  d;
    logic [6:0]  p;
    logic [1:0]  m;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    // R2 program
    '{4'd2, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd2, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd2, 1'b1, 1'b0, 24'h000555, 8'hA0, PN, 2'd0},
    '{4'd2, 1'b1, 1'b0, 24'h012345, 8'h5A, PG, 2'd2},
    // R7 writes ignored while programming, then engine finishes
    '{4'd7, 1'b1, 1'b1, 24'h000555, 8'hAA, PN, 2'd2},
    '{4'd7, 1'b1, 1'b1, 24'h000000, 8'hF0, PN, 2'd2},
    '{4'd7, 1'b0, 1'b0, 24'h000000, 8'h00, PN, 2'd0},
    // R3 chip erase
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'h80, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'h10, CH, 2'd2},
    // R7 chip erase cannot be suspended
    '{4'd7, 1'b1, 1'b1, 24'h000000, 8'hB0, PN, 2'd2},
    '{4'd7, 1'b0, 1'b0, 24'h000000, 8'h00, PN, 2'd0},
    // R3 sector erase
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'h80, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd3, 1'b1, 1'b0, 24'h1F0000, 8'h30, SE, 2'd2},
    // R8 suspend
    '{4'd8, 1'b0, 1'b1, 24'h000000, 8'h00, PN, 2'd2},
    '{4'd8, 1'b1, 1'b1, 24'h000000, 8'hB0, SU, 2'd3},
    // R9 erase set-up and reset refused while suspended
    '{4'd9, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd3},
    '{4'd9, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd3},
    '{4'd9, 1'b1, 1'b0, 24'h000555, 8'h80, PN, 2'd3},
    '{4'd9, 1'b1, 1'b0, 24'h000000, 8'hF0, PN, 2'd3},
    // R9 program inside suspended erase, then back to suspended
    '{4'd9, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd3},
    '{4'd9, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd3},
    '{4'd9, 1'b1, 1'b0, 24'h000555, 8'hA0, PN, 2'd3},
    '{4'd9, 1'b1, 1'b0, 24'h020010, 8'h66, PG, 2'd2},
    '{4'd9, 1'b0, 1'b1, 24'h000000, 8'h00, PN, 2'd2},
    '{4'd9, 1'b0, 1'b0, 24'h000000, 8'h00, PN, 2'd3},
    // R9 resume
    '{4'd9, 1'b1, 1'b0, 24'h000000, 8'h30, RS, 2'd2},
    '{4'd9, 1'b0, 1'b1, 24'h000000, 8'h00, PN, 2'd2},
    '{4'd9, 1'b0, 1'b0, 24'h000000, 8'h00, PN, 2'd0},
    // R9 lone resume and suspend have no effect in read mode
    '{4'd9, 1'b1, 1'b0, 24'h000000, 8'h30, PN, 2'd0},
    '{4'd9, 1'b1, 1'b0, 24'h000000, 8'hB0, PN, 2'd0},
    // R4 identifier entry
    '{4'd4, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd4, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd4, 1'b1, 1'b0, 24'h000555, 8'h90, ID, 2'd1},
    // R5 reset from identifier mode
    '{4'd5, 1'b1, 1'b0, 24'h000000, 8'hF0, RT, 2'd0},
    // R6 wrong second-cycle address aborts
    '{4'd6, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd6, 1'b1, 1'b0, 24'h0002AB, 8'h55, PN, 2'd0},
    '{4'd6, 1'b1, 1'b0, 24'h000555, 8'hA0, PN, 2'd0},
    '{4'd6, 1'b1, 1'b0, 24'h000123, 8'h77, PN, 2'd0},
    // R6 wrong third-cycle data aborts
    '{4'd6, 1'b1, 1'b0, 24'h000555, 8'hAA, PN, 2'd0},
    '{4'd6, 1'b1, 1'b0, 24'h0002AA, 8'h55, PN, 2'd0},
    '{4'd6, 1'b1, 1'b0, 24'h000555, 8'hA1, PN, 2'd0},
    '{4'd6, 1'b1, 1'b0, 24'h000012, 8'h77, PN, 2'd0},
    // R1 upper address bits are not compared
    '{4'd1, 1'b1, 1'b0, 24'h1FF555, 8'hAA, PN, 2'd0},
    '{4'd1, 1'b1, 1'b0, 24'h0AA2AA, 8'h55, PN, 2'd0},
    '{4'd1, 1'b1, 1'b0, 24'h155555, 8'hA0, PN, 2'd0},
    '{4'd1, 1'b1, 1'b0, 24'h000100, 8'hFF, PG, 2'd2},
    '{4'd7, 1'b0, 1'b1, 24'h000000, 8'h00, PN, 2'd2},
    '{4'd7, 1'b0, 1'b0, 24'h000000, 8'h00, PN, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          eng_busy = 1'b0;
  logic          eng_fail = 1'b0;
  logic          grp_locked = 1'b0;
  logic          go_reset, go_program, go_chip_erase, go_sector_erase;
  logic          go_suspend, go_resume, go_id_enter, go_prot_query;
  logic [AW-1:0] op_addr, qry_addr;
  logic [7:0]    op_data, id_data;
  logic          id_valid;
  logic [1:0]    mode;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nor_cmd_decoder #(.AW(AW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_en (rd_en), .rd_addr (rd_addr),
    .eng_busy (eng_busy), .eng_fail (eng_fail), .grp_locked (grp_locked),
    .go_reset (go_reset), .go_program (go_program), .go_chip_erase (go_chip_erase),
    .go_sector_erase (go_sector_erase), .go_suspend (go_suspend), .go_resume (go_resume),
    .go_id_enter (go_id_enter), .go_prot_query (go_prot_query),
    .op_addr (op_addr), .op_data (op_data), .qry_addr (qry_addr),
    .id_valid (id_valid), .id_data (id_data), .mode (mode)
  );

  function automatic logic [6:0] pulses();
    return {go_reset, go_program, go_chip_erase, go_sector_erase, go_suspend, go_resume, go_id_enter};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One cycle: inputs set at a falling edge, outputs sampled at the next one.
  task automatic cyc(input logic we, input logic busy, input logic [AW-1:0] a, input logic [7:0] d);
    wr_en    = we;
    eng_busy = busy;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock();
    cyc(1'b1, 1'b0, 21'h000555, 8'hAA);
    cyc(1'b1, 1'b0, 21'h0002AA, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk("R5 reset mode", 32'(mode), 32'd0);
    chk("R5 reset pulses", 32'(pulses()), 32'd0);
    chk("R5 reset id_valid", 32'(id_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].we, VEC[i].busy, VEC[i].a[AW-1:0], VEC[i].d);
      chk($sformatf("R%0d vec %0d pulses", VEC[i].r, i), 32'(pulses()), 32'(VEC[i].p));
      chk($sformatf("R%0d vec %0d mode", VEC[i].r, i), 32'(mode), 32'(VEC[i].m));
    end

    // R2 latched program address and data from the last program in the table
    chk("R2 op_addr", 32'(op_addr), 32'h000100);
    chk("R2 op_data", 32'(op_data), 32'hFF);

    // R3 sector erase latches the sector address
    unlock();
    cyc(1'b1, 1'b0, 21'h000555, 8'h80);
    unlock();
    cyc(1'b1, 1'b0, 21'h0A1234, 8'h30);
    chk("R3 sector pulse", 32'(go_sector_erase), 32'd1);
    chk("R3 sector op_addr", 32'(op_addr), 32'h0A1234);
    cyc(1'b0, 1'b1, '0, '0);
    cyc(1'b0, 1'b0, '0, '0);
    chk("R7 sector done mode", 32'(mode), 32'd0);

    // R3 wrong sixth-cycle data aborts
    unlock();
    cyc(1'b1, 1'b0, 21'h000555, 8'h80);
    unlock();
    cyc(1'b1, 1'b0, 21'h000555, 8'h20);
    chk("R3 bad sixth pulses", 32'(pulses()), 32'd0);
    chk("R3 bad sixth mode", 32'(mode), 32'd0);

    // R4 identifier reads
    rd(21'h000000);
    chk("R4 read outside id mode", 32'(id_valid), 32'd0);
    unlock();
    cyc(1'b1, 1'b0, 21'h000555, 8'h90);
    chk("R4 id mode", 32'(mode), 32'd1);
    rd(21'h000000);
    chk("R4 mfr valid", 32'(id_valid), 32'd1);
    chk("R4 mfr byte", 32'(id_data), 32'hC2);
    rd(21'h000001);
    chk("R4 dev byte", 32'(id_data), 32'hAD);
    grp_locked = 1'b1;
    rd(21'h1C0002);
    chk("R4 locked byte", 32'(id_data), 32'h01);
    chk("R4 query pulse", 32'(go_prot_query), 32'd1);
    chk("R4 query addr", 32'(qry_addr), 32'h1C0002);
    grp_locked = 1'b0;
    rd(21'h000002);
    chk("R4 unlocked byte", 32'(id_data), 32'h00);
    cyc(1'b1, 1'b0, 21'h000000, 8'hF0);
    chk("R5 leave id mode", 32'(mode), 32'd0);

    // R10 read strobe in the middle of a sequence
    unlock();
    rd(21'h000555);
    cyc(1'b1, 1'b0, 21'h000555, 8'hA0);
    rd(21'h000000);
    cyc(1'b1, 1'b0, 21'h000444, 8'h3C);
    chk("R10 program after reads", 32'(go_program), 32'd1);
    chk("R10 op_data", 32'(op_data), 32'h3C);

    // R5 reset accepted while busy only with a failure reported
    cyc(1'b0, 1'b1, '0, '0);
    cyc(1'b1, 1'b1, 21'h000000, 8'hF0);
    chk("R7 reset ignored without fail", 32'(mode), 32'd2);
    eng_fail = 1'b1;
    cyc(1'b1, 1'b1, 21'h000000, 8'hF0);
    chk("R5 fail reset pulse", 32'(go_reset), 32'd1);
    chk("R5 fail reset mode", 32'(mode), 32'd0);
    eng_fail = 1'b0;
    cyc(1'b0, 1'b0, '0, '0);
    chk("R11 pulse lasts one cycle", 32'(pulses()), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule